// File: doc/BRIEF.md
# Peripheral Bridge with Posted-Write Queue

The bridge sits between one system-bus slave port and a simple peripheral bus with up to `N_SLOT` peripheral slots. The slot is chosen by the top `log2(N_SLOT)` address bits. Every request carries a master ID and a supervisor flag. The bridge checks it against per-master rights and per-slot attributes before it forwards anything. A denied access never reaches a peripheral. It is answered with an error.

Writes to a slot marked as buffered are posted. They are accepted in one cycle and answered on the next cycle. They wait in a two-entry queue and are then carried out on the peripheral bus in acceptance order. Reads, and writes to unbuffered slots, wait until the queue has drained and the peripheral bus is idle. They are then performed directly, and the system side gets its response one cycle after the peripheral acknowledges.

The system request is valid/ready. A request is taken on a clock edge where `sys_valid` and `sys_ready` are both high, and it must stay unchanged until then. `sys_ready` is low in three cases:
- a direct transfer is outstanding;
- a posted write meets a full queue;
- a direct access meets a non-empty queue or a busy peripheral bus.

The response is a single-cycle `rsp_valid` pulse with no back-pressure. Each accepted request gets exactly one response. `N_SLOT` must be a power of two and no smaller than the number of masters.

Top module: `pbr_bridge`

## Requirements
- R1: After reset, `per_req` and `rsp_valid` are low and both control words read 0. With idle inputs, `sys_ready` is high. Buffering is off, so a write to any slot is performed directly. Reset discards queued and in-flight posted writes.
- R2: A permitted read raises `per_req` with the address held until `per_ack`. `rsp_valid` pulses in the cycle after the edge that samples `per_ack`, with `rsp_rdata` equal to `per_rdata` and `rsp_err` low.
- R3: A permitted write to an unbuffered slot follows the R2 timing, with `per_write` high, the request data on `per_wdata`, and `rsp_rdata` 0.
- R4: A permitted write to a buffered slot is answered in the cycle after acceptance, with `rsp_err` low. It is later performed on the peripheral bus with its address and data.
- R5: The queue holds two posted writes besides the one in flight. A further posted write sees `sys_ready` low until an entry leaves.
- R6: A read or unbuffered write is not accepted while the queue is non-empty or a peripheral transfer is in progress. The peripheral bus sees transfers in acceptance order.
- R7: For a slot with its trusted-only bit set, a read needs the master's read-trust bit and a write needs the master's write-trust bit.
- R8: For a slot with its supervisor-only bit set, an access needs `sys_super` high and the master's force-user bit clear.
- R9: A denied access is never forwarded and is accepted without waiting for the queue. It is answered in the next cycle with `rsp_err` high and `rsp_rdata` 0.
- R10: A control write applies only to accesses accepted after its edge. Posted writes already queued are still performed.
- R11: Control word `cfg_sel`=0 holds read-trust in bits 7:0, write-trust in bits 15:8 and force-user in bits 23:16, with bit m of each field belonging to master m. Word 1 holds the buffered bits in 7:0, supervisor-only in 15:8 and trusted-only in 23:16, with bit s belonging to slot s. Both words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_valid | input | 1 | System request valid |
| sys_ready | output | 1 | System request accepted on this edge when valid |
| sys_addr | input | ADDR_W (16) | Request address; top bits select the slot |
| sys_write | input | 1 | 1 = write, 0 = read |
| sys_wdata | input | DATA_W (32) | Write data |
| sys_mid | input | MID_W (2) | Requesting master ID |
| sys_super | input | 1 | Supervisor flag of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an access error |
| rsp_rdata | output | DATA_W (32) | Read data of the response |
| per_req | output | 1 | Peripheral transfer request, held until acknowledge |
| per_addr | output | ADDR_W (16) | Peripheral address |
| per_write | output | 1 | Peripheral transfer direction |
| per_wdata | output | DATA_W (32) | Peripheral write data |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | DATA_W (32) | Peripheral read data, valid with `per_ack` |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 1 | Control word select: 0 masters, 1 slots |
| cfg_wdata | input | 3*N_SLOT (24) | Control word write value |
| cfg_rdata | output | 3*N_SLOT (24) | Selected control word |

## Verification
The assertions assume three things about the inputs:
- `per_ack` is raised only while `per_req` is high, and for one cycle.
- A system request is not changed between raising `sys_valid` and its acceptance.
- Control writes do not race an access whose outcome they would change.

The peripheral model in the bench acknowledges once, for one cycle, and only after it sees a pending request. It can be told to withhold the acknowledge, which keeps entries in the queue. All system and control inputs change only at the falling edge, and a request is held until `sys_ready` is seen high.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;

  localparam logic CFG_SEL_MASTER = 1'b0;
  localparam logic CFG_SEL_SLOT   = 1'b1;
endpackage

// File: rtl/pbr_cfg_regs.sv
module pbr_cfg_regs #(
  parameter int N_MST  = 4,
  parameter int N_SLOT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [3*N_SLOT-1:0]   cfg_wdata,
  output logic [3*N_SLOT-1:0]   cfg_rdata,
  output logic [N_MST-1:0]      trust_rd,
  output logic [N_MST-1:0]      trust_wr,
  output logic [N_MST-1:0]      force_user,
  output logic [N_SLOT-1:0]     slot_buf,
  output logic [N_SLOT-1:0]     slot_sup,
  output logic [N_SLOT-1:0]     slot_trust
);
  import pbr_pkg::*;

  localparam int FW = N_SLOT;
  localparam int RW = 3 * FW;

  logic [RW-1:0] mst_q;
  logic [RW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q  <= '0;
      slot_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_SEL_SLOT) slot_q <= cfg_wdata;
      else                         mst_q  <= cfg_wdata;
    end
  end

  assign cfg_rdata = (cfg_sel == CFG_SEL_SLOT) ? slot_q : mst_q;

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    assign trust_rd[m]   = mst_q[m];
    assign trust_wr[m]   = mst_q[FW + m];
    assign force_user[m] = mst_q[2*FW + m];
  end

  assign slot_buf   = slot_q[FW-1:0];
  assign slot_sup   = slot_q[2*FW-1:FW];
  assign slot_trust = slot_q[3*FW-1:2*FW];
endmodule

// File: rtl/pbr_access_check.sv
module pbr_access_check #(
  parameter int MID_W  = 2,
  parameter int SLOT_W = 3,
  localparam int N_MST  = 1 << MID_W,
  localparam int N_SLOT = 1 << SLOT_W
) (
  input  logic [MID_W-1:0]  mid,
  input  logic              super_in,
  input  logic              write,
  input  logic [SLOT_W-1:0] slot,
  input  logic [N_MST-1:0]  trust_rd,
  input  logic [N_MST-1:0]  trust_wr,
  input  logic [N_MST-1:0]  force_user,
  input  logic [N_SLOT-1:0] slot_buf,
  input  logic [N_SLOT-1:0] slot_sup,
  input  logic [N_SLOT-1:0] slot_trust,
  output logic              deny,
  output logic              posted
);
  logic eff_super;
  logic trusted;
  logic sup_fail;
  logic trust_fail;

  always_comb begin
    // privilege after the per-master user-mode override
    eff_super  = super_in & ~force_user[mid];
    trusted    = write ? trust_wr[mid] : trust_rd[mid];
    sup_fail   = slot_sup[slot] & ~eff_super;
    trust_fail = slot_trust[slot] & ~trusted;
    deny       = sup_fail | trust_fail;
    posted     = write & slot_buf[slot] & ~deny;
  end
endmodule

// File: rtl/pbr_post_queue.sv
module pbr_post_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign head_addr = addr_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R4
endmodule

// File: rtl/pbr_periph_engine.sv
module pbr_periph_engine #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_data,
  output logic          q_pop,
  input  logic          dir_start,
  input  logic [AW-1:0] dir_addr,
  input  logic          dir_write,
  input  logic [DW-1:0] dir_wdata,
  output logic          eng_idle,
  output logic          per_req,
  output logic [AW-1:0] per_addr,
  output logic          per_write,
  output logic [DW-1:0] per_wdata,
  input  logic          per_ack,
  input  logic [DW-1:0] per_rdata,
  output logic          done_dir,
  output logic [DW-1:0] done_rdata
);
  import pbr_pkg::*;

  eng_state_e    state_q;
  logic          is_dir_q;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;

  assign q_pop = (state_q == ENG_IDLE) && q_valid && !dir_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      is_dir_q <= 1'b0;
      addr_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (dir_start) begin
            state_q  <= ENG_BUSY;
            is_dir_q <= 1'b1;
            addr_q   <= dir_addr;
            write_q  <= dir_write;
            wdata_q  <= dir_wdata;
          end else if (q_valid) begin
            state_q  <= ENG_BUSY;
            is_dir_q <= 1'b0;
            addr_q   <= q_addr;
            write_q  <= 1'b1;
            wdata_q  <= q_data;
          end
        end
        default: begin
          if (per_ack) state_q <= ENG_IDLE;
        end
      endcase
    end
  end

  assign eng_idle   = (state_q == ENG_IDLE);
  assign per_req    = (state_q == ENG_BUSY);
  assign per_addr   = addr_q;
  assign per_write  = write_q;
  assign per_wdata  = wdata_q;
  assign done_dir   = per_req && per_ack && is_dir_q;
  assign done_rdata = write_q ? '0 : per_rdata;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_ack |=> per_req && $stable(per_addr) && $stable(per_wdata)); // R2
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && per_ack |=> !per_req); // R2
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dir_start |-> state_q == ENG_IDLE); // R6
endmodule

// File: rtl/pbr_bridge.sv
module pbr_bridge #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int MID_W   = 2,
  parameter int N_SLOT  = 8,
  parameter int Q_DEPTH = 2,
  localparam int CFG_W  = 3 * N_SLOT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_valid,
  output logic              sys_ready,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic              sys_write,
  input  logic [DATA_W-1:0] sys_wdata,
  input  logic [MID_W-1:0]  sys_mid,
  input  logic              sys_super,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              per_req,
  output logic [ADDR_W-1:0] per_addr,
  output logic              per_write,
  output logic [DATA_W-1:0] per_wdata,
  input  logic              per_ack,
  input  logic [DATA_W-1:0] per_rdata,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata
);
  localparam int N_MST    = 1 << MID_W;
  localparam int SLOT_W   = $clog2(N_SLOT);
  localparam int SLOT_LSB = ADDR_W - SLOT_W;

  logic [N_MST-1:0]  trust_rd, trust_wr, force_user;
  logic [N_SLOT-1:0] slot_buf, slot_sup, slot_trust;
  logic [SLOT_W-1:0] slot;
  logic              deny, posted, direct;
  logic              accept, push, dir_start;
  logic              q_empty, q_full, q_pop;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  logic              eng_idle, done_dir;
  logic [DATA_W-1:0] done_rdata;
  logic              dir_busy;

  pbr_cfg_regs #(.N_MST(N_MST), .N_SLOT(N_SLOT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .trust_rd(trust_rd), .trust_wr(trust_wr), .force_user(force_user),
    .slot_buf(slot_buf), .slot_sup(slot_sup), .slot_trust(slot_trust)
  );

  assign slot = sys_addr[SLOT_LSB +: SLOT_W];

  pbr_access_check #(.MID_W(MID_W), .SLOT_W(SLOT_W)) u_chk (
    .mid(sys_mid), .super_in(sys_super), .write(sys_write), .slot(slot),
    .trust_rd(trust_rd), .trust_wr(trust_wr), .force_user(force_user),
    .slot_buf(slot_buf), .slot_sup(slot_sup), .slot_trust(slot_trust),
    .deny(deny), .posted(posted)
  );

  assign direct = !deny && !posted;

  // back-pressure: one direct transfer at a time, posted writes need a free
  // slot, direct accesses need a drained queue and an idle peripheral side
  always_comb begin
    if (dir_busy)     sys_ready = 1'b0;
    else if (deny)    sys_ready = 1'b1;
    else if (posted)  sys_ready = !q_full;
    else              sys_ready = q_empty && eng_idle;
  end

  assign accept    = sys_valid && sys_ready;
  assign push      = accept && posted;
  assign dir_start = accept && direct;

  pbr_post_queue #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(sys_addr),
    .push_data(sys_wdata), .pop(q_pop), .head_addr(q_addr),
    .head_data(q_data), .empty(q_empty), .full(q_full)
  );

  pbr_periph_engine #(.AW(ADDR_W), .DW(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .q_valid(!q_empty), .q_addr(q_addr),
    .q_data(q_data), .q_pop(q_pop), .dir_start(dir_start),
    .dir_addr(sys_addr), .dir_write(sys_write), .dir_wdata(sys_wdata),
    .eng_idle(eng_idle), .per_req(per_req), .per_addr(per_addr),
    .per_write(per_write), .per_wdata(per_wdata), .per_ack(per_ack),
    .per_rdata(per_rdata), .done_dir(done_dir), .done_rdata(done_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_busy  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (dir_start)     dir_busy <= 1'b1;
      else if (done_dir) dir_busy <= 1'b0;
      rsp_valid <= (accept && (deny || posted)) || done_dir;
      rsp_err   <= accept && deny;
      rsp_rdata <= done_dir ? done_rdata : '0;
    end
  end

  AST_POST_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rsp_valid && !rsp_err); // R4
  AST_DENY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    accept && deny |=> rsp_valid && rsp_err && rsp_rdata == '0); // R9
  AST_DIRECT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    dir_start |-> q_empty && !per_req); // R6
  AST_ONE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_busy |-> !push && !dir_start); // R2
endmodule

// File: tb/sim_pbr_bridge.sv
`timescale 1ns/1ps
module sim_pbr_bridge;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_valid = 1'b0, sys_write = 1'b0, sys_super = 1'b0;
  logic          sys_ready;
  logic [AW-1:0] sys_addr = '0;
  logic [DW-1:0] sys_wdata = '0;
  logic [1:0]    sys_mid = '0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          per_req, per_write;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata;
  logic          per_ack = 1'b0;
  logic [DW-1:0] per_rdata = '0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rdata;

  int checks = 0;
  int fails  = 0;
  bit hold   = 0;
  int lat_cfg = 1;
  logic [AW-1:0] log_addr [256];
  logic          log_wr   [256];
  logic [DW-1:0] log_data [256];
  int log_n = 0;

  // vector: {mid[7:6], super[5], write[4], slot[3:1], expected error[0]}
  localparam logic [7:0] VEC [13] = '{
    8'b00000000, 8'b00000011, 8'b00110010, 8'b01000100, 8'b01010101,
    8'b10010100, 8'b10000101, 8'b11100011, 8'b11010100, 8'b00110110,
    8'b01110111, 8'b11100111, 8'b10110000
  };
  localparam logic [CW-1:0] MST_WORD  = 24'h080D0B;
  localparam logic [CW-1:0] SLOT_WORD = 24'h0C0A30;

  pbr_bridge u0 (
    .clk(clk), .rst_n(rst_n), .sys_valid(sys_valid), .sys_ready(sys_ready),
    .sys_addr(sys_addr), .sys_write(sys_write), .sys_wdata(sys_wdata),
    .sys_mid(sys_mid), .sys_super(sys_super), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .per_req(per_req),
    .per_addr(per_addr), .per_write(per_write), .per_wdata(per_wdata),
    .per_ack(per_ack), .per_rdata(per_rdata), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // peripheral model: acknowledges one cycle, lat_cfg cycles into a request
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (per_ack) per_ack = 1'b0;
      else if (per_req && !hold) begin
        wcnt++;
        if (wcnt >= lat_cfg) begin
          per_ack   = 1'b1;
          per_rdata = {16'hA5C3, per_addr};
          log_addr[log_n] = per_addr;
          log_wr[log_n]   = per_write;
          log_data[log_n] = per_wdata;
          log_n++;
          wcnt = 0;
        end
      end else if (!per_req) wcnt = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic cfg_write(input logic sel, input logic [CW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic sel, output logic [CW-1:0] val);
    @(negedge clk);
    cfg_sel = sel;
    #1 val = cfg_rdata;
  endtask

  task automatic drive(input logic [1:0] mid, input logic sup, input logic wr,
                       input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    sys_valid = 1'b1; sys_mid = mid; sys_super = sup;
    sys_write = wr; sys_addr = addr; sys_wdata = wd;
  endtask

  task automatic do_acc(input logic [1:0] mid, input logic sup, input logic wr,
                        input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        output int lat, output logic err, output logic [DW-1:0] rd);
    int w;
    lat = 0; err = 1'bx; rd = 'x;
    @(negedge clk);
    drive(mid, sup, wr, addr, wd);
    #1;
    w = 0;
    while (!sys_ready && w < 500) begin
      @(negedge clk); #1; w++;
    end
    if (!sys_ready) begin
      chk("R2", "accept timeout", 32'd0, 32'd1);
      sys_valid = 1'b0;
      return;
    end
    @(posedge clk);
    @(negedge clk);
    sys_valid = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      if (rsp_valid) begin
        lat = k; err = rsp_err; rd = rsp_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_log(input int n);
    int w;
    w = 0;
    while (log_n < n && w < 2000) begin
      @(negedge clk); w++;
    end
  endtask

  initial begin
    int lat;
    logic err;
    logic [DW-1:0] rd;
    logic [CW-1:0] cv;
    int base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    chk("R1", "per_req after reset", 32'(per_req), 32'd0);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "sys_ready idle", 32'(sys_ready), 32'd1);
    cfg_read(1'b0, cv); chk("R1", "master word reset", 32'(cv), 32'd0);
    cfg_read(1'b1, cv); chk("R1", "slot word reset", 32'(cv), 32'd0);
    base = log_n;
    do_acc(2'd0, 1'b0, 1'b1, 16'h8000, 32'h0BAD_0001, lat, err, rd);
    chk("R1", "slot4 write unbuffered after reset: latency", 32'(lat), 32'd2);
    chk("R1", "write performed", 32'(log_n - base), 32'd1);

    // R11: control layout and readback
    cfg_write(1'b0, MST_WORD);
    cfg_write(1'b1, SLOT_WORD);
    cfg_read(1'b0, cv); chk("R11", "master word readback", 32'(cv), 32'(MST_WORD));
    cfg_read(1'b1, cv); chk("R11", "slot word readback", 32'(cv), 32'(SLOT_WORD));

    // R7,R8,R9: permission vector table on unbuffered slots
    for (int i = 0; i < 13; i++) begin
      logic [AW-1:0] a;
      logic exp_err;
      a = {VEC[i][3:1], 13'(i * 4)};
      exp_err = VEC[i][0];
      base = log_n;
      do_acc(VEC[i][7:6], VEC[i][5], VEC[i][4], a, 32'hC0DE_0000 + 32'(i), lat, err, rd);
      chk("R7,R8", $sformatf("vector %0d error", i), 32'(err), 32'(exp_err));
      chk("R9", $sformatf("vector %0d latency", i), 32'(lat), exp_err ? 32'd1 : 32'd2);
      chk("R9", $sformatf("vector %0d forwarded", i), 32'(log_n - base), exp_err ? 32'd0 : 32'd1);
      if (!VEC[i][4] && !exp_err)
        chk("R2", $sformatf("vector %0d read data", i), rd, {16'hA5C3, a});
    end

    // R2: read with a slower peripheral, latency = wait + 1
    lat_cfg = 3;
    do_acc(2'd0, 1'b0, 1'b0, 16'h0124, '0, lat, err, rd);
    chk("R2", "slow read latency", 32'(lat), 32'd4);
    chk("R2", "slow read data", rd, 32'hA5C3_0124);
    chk("R2", "slow read error", 32'(err), 32'd0);

    // R3: unbuffered write
    base = log_n;
    do_acc(2'd0, 1'b0, 1'b1, 16'h0200, 32'h1234_5678, lat, err, rd);
    chk("R3", "write latency", 32'(lat), 32'd4);
    chk("R3", "write rdata", rd, 32'd0);
    chk("R3", "write data at peripheral", log_data[base], 32'h1234_5678);
    chk("R3", "write flag at peripheral", 32'(log_wr[base]), 32'd1);
    lat_cfg = 1;

    // R4: posted write
    base = log_n;
    do_acc(2'd1, 1'b0, 1'b1, 16'h8010, 32'hFEED_0010, lat, err, rd);
    chk("R4", "posted latency", 32'(lat), 32'd1);
    chk("R4", "posted error", 32'(err), 32'd0);
    wait_log(base + 1);
    chk("R4", "posted address", 32'(log_addr[base]), 32'h8010);
    chk("R4", "posted data", log_data[base], 32'hFEED_0010);

    // R5: two queued entries plus one in flight, then stall
    repeat (3) @(negedge clk);
    base = log_n;
    hold = 1;
    for (int i = 0; i < 3; i++) begin
      do_acc(2'd0, 1'b0, 1'b1, 16'h8000 + 16'(i * 4), 32'h1000_0000 + 32'(i), lat, err, rd);
      chk("R5", $sformatf("posted %0d latency", i), 32'(lat), 32'd1);
    end
    @(negedge clk);
    drive(2'd0, 1'b0, 1'b1, 16'h800C, 32'h1000_0003);
    begin
      int hi;
      hi = 0;
      for (int k = 0; k < 4; k++) begin
        #1 if (sys_ready) hi++;
        @(negedge clk);
      end
      chk("R5", "fourth posted write stalled", 32'(hi), 32'd0);
    end
    sys_valid = 1'b0;
    hold = 0;
    do_acc(2'd0, 1'b0, 1'b1, 16'h800C, 32'h1000_0003, lat, err, rd);
    chk("R5", "fourth posted latency", 32'(lat), 32'd1);
    wait_log(base + 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5", $sformatf("drain order %0d", i), 32'(log_addr[base + i]), 32'h8000 + 32'(i * 4));
      chk("R5", $sformatf("drain data %0d", i), log_data[base + i], 32'h1000_0000 + 32'(i));
    end

    // R6: read waits behind posted writes
    repeat (3) @(negedge clk);
    base = log_n;
    hold = 1;
    do_acc(2'd0, 1'b0, 1'b1, 16'hA000, 32'hAAAA_0000, lat, err, rd);
    do_acc(2'd0, 1'b0, 1'b1, 16'hA004, 32'hAAAA_0004, lat, err, rd);
    @(negedge clk);
    drive(2'd0, 1'b0, 1'b0, 16'h0010, '0);
    begin
      int hi;
      hi = 0;
      for (int k = 0; k < 4; k++) begin
        #1 if (sys_ready) hi++;
        @(negedge clk);
      end
      chk("R6", "read held while queue busy", 32'(hi), 32'd0);
    end
    sys_valid = 1'b0;
    hold = 0;
    do_acc(2'd0, 1'b0, 1'b0, 16'h0010, '0, lat, err, rd);
    chk("R6", "read data after drain", rd, 32'hA5C3_0010);
    chk("R6", "order first", 32'(log_addr[base]), 32'hA000);
    chk("R6", "order second", 32'(log_addr[base + 1]), 32'hA004);
    chk("R6", "order read last", 32'(log_addr[base + 2]), 32'h0010);

    // R10, R9: settings change with a write queued
    repeat (3) @(negedge clk);
    base = log_n;
    hold = 1;
    do_acc(2'd1, 1'b0, 1'b1, 16'h8100, 32'h5555_0000, lat, err, rd);
    chk("R10", "queued before change error", 32'(err), 32'd0);
    cfg_write(1'b1, 24'h0C1A30);
    do_acc(2'd1, 1'b0, 1'b1, 16'h8104, 32'h5555_0004, lat, err, rd);
    chk("R10", "after change error", 32'(err), 32'd1);
    chk("R9", "denied answered while queue busy", 32'(lat), 32'd1);
    hold = 0;
    wait_log(base + 1);
    repeat (10) @(negedge clk);
    chk("R10", "only queued write performed", 32'(log_n - base), 32'd1);
    chk("R10", "queued write address", 32'(log_addr[base]), 32'h8100);
    cfg_write(1'b1, SLOT_WORD);

    // R1: reset discards queued writes
    repeat (3) @(negedge clk);
    base = log_n;
    hold = 1;
    do_acc(2'd0, 1'b0, 1'b1, 16'h8200, 32'h7777_0000, lat, err, rd);
    do_acc(2'd0, 1'b0, 1'b1, 16'h8204, 32'h7777_0004, lat, err, rd);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    hold = 0;
    rst_n = 1'b1;
    #1;
    chk("R1", "per_req after mid-run reset", 32'(per_req), 32'd0);
    repeat (10) @(negedge clk);
    chk("R1", "queue discarded by reset", 32'(log_n - base), 32'd0);
    cfg_read(1'b1, cv); chk("R1", "slot word cleared", 32'(cv), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule